// File: doc/BRIEF.md
# Linked-List FIFO Channel Sequencer

This block decides, once per 8 kHz frame, which data FIFO exchanges a byte with which time-division channel. Each channel moves one byte per frame. A FIFO that needs more than that rate is listed against several channels. The routing is held in a small table of linked entries. Each entry names a FIFO, a channel, a transfer direction, the index of the following entry, and whether it closes the list. On every frame strobe the sequencer starts at a programmable head index and follows the links. For each entry it emits one byte-transfer command on a valid/ready interface, and it stops after the entry marked as last. A single FIFO may appear in any number of entries. In the transmit direction its bytes then go out on those channels in list order. In the receive direction bytes from those channels are gathered into it in the same order. A list of one entry gives an ordinary one-to-one pairing.

A mode input chooses between this linked walk and a fixed fallback. With the mode low, each frame produces a short ascending sweep that pairs FIFO k with channel k. The table is loaded through an index/data write port. Writes are accepted only while no walk is live, so a list is never changed part way through a frame. A step limit ends a list whose links form a loop, and a sticky flag records that this happened. A second sticky flag records a frame strobe that arrives before the previous walk has finished.

Top module: `chan_seq_walker`

## Requirements
- R1: After reset, cmd_valid, runaway_err and overrun_err are all low, and every table entry holds zero.
- R2: When cfg_we is high and no command is pending (cmd_valid low), the entry at cfg_idx is loaded from cfg_data at the clock edge. The cfg_data layout from bit 0 upward is: FIFO number (FIFO_W bits), direction bit (1 = receive, 0 = transmit), channel number (CHAN_W bits), next index (log2 ENTRIES bits), and last flag at the top bit.
- R3: A frame_tick with seq_mode high starts a walk at head_idx. From the next cycle, each accepted command carries the current entry's FIFO, channel and direction. The walk then moves to that entry's next index. The walk ends after the command for an entry whose last flag is set.
- R4: A command is accepted only on a cycle with cmd_valid and cmd_ready both high. While cmd_valid is high and cmd_ready is low, cmd_fifo, cmd_chan and cmd_dir hold their values.
- R5: A one-entry list, where the head entry has its last flag set, yields exactly one command per frame.
- R6: A walk that has issued ENTRIES commands without meeting a last entry stops and sets runaway_err. runaway_err then stays high until reset. A list of exactly ENTRIES entries that ends on a last entry does not set it.
- R7: A frame_tick that arrives while cmd_valid is high sets overrun_err, which stays high until reset. The walk restarts from head_idx, so the full list is issued afresh.
- R8: A cfg_we write presented while cmd_valid is high is discarded. Later walks use the earlier table contents.
- R9: A change of seq_mode during a walk drops cmd_valid in the same cycle and ends the walk. No further command appears until the next frame_tick.
- R10: A frame_tick with seq_mode low issues SIMPLE_CNT commands, with k = 0, 1, … in order. Command k has cmd_fifo = cmd_chan = k and cmd_dir = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seq_mode | input | 1 | 1 = linked-list walk, 0 = fixed one-to-one sweep |
| frame_tick | input | 1 | One-cycle frame strobe |
| head_idx | input | log2(ENTRIES) | First entry of the list |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | log2(ENTRIES) | Entry written |
| cfg_data | input | FIFO_W+CHAN_W+log2(ENTRIES)+2 | Packed entry contents |
| cmd_valid | output | 1 | Transfer command pending |
| cmd_ready | input | 1 | Downstream accepts the command |
| cmd_fifo | output | FIFO_W | FIFO number of the command |
| cmd_chan | output | CHAN_W | Channel number of the command |
| cmd_dir | output | 1 | 1 = channel to FIFO, 0 = FIFO to channel |
| runaway_err | output | 1 | Sticky: a walk hit the step limit |
| overrun_err | output | 1 | Sticky: a frame strobe arrived mid-walk |

## Verification
The assertions assume three things about the inputs: frame_tick is a one-cycle pulse, head_idx is stable through each walk, and seq_mode changes only at a clock edge. The hold-while-stalled property also allows for the cycle right after a seq_mode change or a frame strobe, because either one legitimately abandons the pending command. The bench drives every input on the falling edge and pulses frame_tick for exactly one cycle. It moves seq_mode only during the abort scenario, so the walks it inspects run under stable inputs. It sweeps list lengths from one up to the full small table, on a stride-three permutation of indices, with and without downstream stalls.

// File: rtl/chseq_pkg.sv
package chseq_pkg;
   typedef enum logic [1:0] {
      WK_IDLE   = 2'd0,
      WK_SEQ    = 2'd1,
      WK_SIMPLE = 2'd2
   } walk_st_t;
endpackage

// File: rtl/chseq_table.sv
module chseq_table #(
   parameter int ENTRIES = 64,
   parameter int ENT_W   = 20,
   localparam int IDX_W  = $clog2(ENTRIES)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [ENT_W-1:0] wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [ENT_W-1:0] rd_data
);
   logic [ENT_W-1:0] mem [ENTRIES];

   // R2: indexed load, cleared by reset (R1)
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (wr_en && wr_idx == IDX_W'(i)) mem[i] <= wr_data;
         end
      end
   end

   assign rd_data = mem[rd_idx];
endmodule

// File: rtl/chseq_walker.sv
module chseq_walker
   import chseq_pkg::*;
#(
   parameter int ENTRIES    = 64,
   parameter int FIFO_W     = 6,
   parameter int CHAN_W     = 6,
   parameter int SIMPLE_CNT = 16,
   localparam int IDX_W     = $clog2(ENTRIES),
   localparam int STEP_W    = $clog2(ENTRIES) + 1,
   localparam int SMP_W     = (SIMPLE_CNT > 1) ? $clog2(SIMPLE_CNT) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seq_mode,
   input  logic              frame_tick,
   input  logic [IDX_W-1:0]  head_idx,
   input  logic              cmd_ready,
   input  logic [FIFO_W-1:0] ent_fifo,
   input  logic              ent_dir,
   input  logic [CHAN_W-1:0] ent_chan,
   input  logic [IDX_W-1:0]  ent_next,
   input  logic              ent_last,
   output logic [IDX_W-1:0]  rd_idx,
   output logic              cmd_valid,
   output logic [FIFO_W-1:0] cmd_fifo,
   output logic [CHAN_W-1:0] cmd_chan,
   output logic              cmd_dir,
   output logic              runaway_err,
   output logic              overrun_err
);
   walk_st_t          st;
   logic [IDX_W-1:0]  cur;
   logic [STEP_W-1:0] steps;
   logic [SMP_W-1:0]  smp_cnt;
   logic              mode_ok;
   logic              fire;
   logic              simple_last;
   walk_st_t          start_st;

   generate
      if (SIMPLE_CNT > 0) begin : g_simple
         assign simple_last = (smp_cnt == SMP_W'(SIMPLE_CNT - 1));
         assign start_st    = WK_SIMPLE;
      end else begin : g_no_simple
         assign simple_last = 1'b1;
         assign start_st    = WK_IDLE;
      end
   endgenerate

   // a walk is live only while the mode input still matches its kind (R9)
   assign mode_ok   = (st == WK_SEQ && seq_mode) || (st == WK_SIMPLE && !seq_mode);
   assign cmd_valid = mode_ok;
   assign fire      = cmd_valid && cmd_ready;
   assign rd_idx    = cur;

   always_comb begin
      if (st == WK_SEQ) begin
         cmd_fifo = ent_fifo;
         cmd_chan = ent_chan;
         cmd_dir  = ent_dir;
      end else begin
         cmd_fifo = FIFO_W'(smp_cnt);
         cmd_chan = CHAN_W'(smp_cnt);
         cmd_dir  = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st          <= WK_IDLE;
         cur         <= '0;
         steps       <= '0;
         smp_cnt     <= '0;
         runaway_err <= 1'b0;
         overrun_err <= 1'b0;
      end else if (frame_tick) begin
         if (mode_ok) overrun_err <= 1'b1;          // R7
         cur     <= head_idx;                        // R3
         steps   <= '0;
         smp_cnt <= '0;
         st      <= seq_mode ? WK_SEQ : start_st;
      end else if (st != WK_IDLE && !mode_ok) begin
         st <= WK_IDLE;                              // R9
      end else if (fire) begin
         if (st == WK_SEQ) begin
            if (ent_last) begin
               st <= WK_IDLE;
            end else if (steps == STEP_W'(ENTRIES - 1)) begin
               st          <= WK_IDLE;               // R6
               runaway_err <= 1'b1;
            end else begin
               cur   <= ent_next;
               steps <= steps + 1'b1;
            end
         end else begin
            if (simple_last) st <= WK_IDLE;          // R10
            else smp_cnt <= smp_cnt + 1'b1;
         end
      end
   end

   // R4
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready && !frame_tick |=>
         (seq_mode != $past(seq_mode)) ||
         (cmd_valid && $stable(cmd_fifo) && $stable(cmd_chan) && $stable(cmd_dir)));

   // R7
   overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_tick && cmd_valid |=> overrun_err);

   // R7
   overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun_err |=> overrun_err);

   // R6
   runaway_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      runaway_err |=> runaway_err);

   // R6
   step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      steps < STEP_W'(ENTRIES));

   // R9
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(seq_mode) && !frame_tick |=> !cmd_valid);

   // R10
   simple_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !seq_mode |-> (32'(cmd_fifo) == 32'(cmd_chan)) && !cmd_dir);
endmodule

// File: rtl/chan_seq_walker.sv
module chan_seq_walker #(
   parameter int ENTRIES    = 64,
   parameter int FIFO_W     = 6,
   parameter int CHAN_W     = 6,
   parameter int SIMPLE_CNT = 16,
   localparam int IDX_W     = $clog2(ENTRIES),
   localparam int ENT_W     = FIFO_W + CHAN_W + IDX_W + 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seq_mode,
   input  logic              frame_tick,
   input  logic [IDX_W-1:0]  head_idx,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [ENT_W-1:0]  cfg_data,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [FIFO_W-1:0] cmd_fifo,
   output logic [CHAN_W-1:0] cmd_chan,
   output logic              cmd_dir,
   output logic              runaway_err,
   output logic              overrun_err
);
   localparam int DIR_BIT  = FIFO_W;
   localparam int CHAN_LO  = FIFO_W + 1;
   localparam int NEXT_LO  = CHAN_LO + CHAN_W;
   localparam int LAST_BIT = NEXT_LO + IDX_W;

   generate
      if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_depth
         $error("ENTRIES must be a power of two, at least 2");
      end
      if (SIMPLE_CNT > (1 << FIFO_W) || SIMPLE_CNT > (1 << CHAN_W)) begin : g_bad_simple
         $error("SIMPLE_CNT exceeds the FIFO or channel number range");
      end
      if (FIFO_W < 1 || CHAN_W < 1) begin : g_bad_width
         $error("FIFO_W and CHAN_W must be positive");
      end
   endgenerate

   logic [IDX_W-1:0] rd_idx;
   logic [ENT_W-1:0] rd_data;
   logic             wr_ok;

   // R8: table frozen while a command is pending
   assign wr_ok = cfg_we && !cmd_valid;

   chseq_table #(.ENTRIES(ENTRIES), .ENT_W(ENT_W)) u_tab (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_ok),
      .wr_idx  (cfg_idx),
      .wr_data (cfg_data),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );

   chseq_walker #(
      .ENTRIES    (ENTRIES),
      .FIFO_W     (FIFO_W),
      .CHAN_W     (CHAN_W),
      .SIMPLE_CNT (SIMPLE_CNT)
   ) u_walk (
      .clk         (clk),
      .rst_n       (rst_n),
      .seq_mode    (seq_mode),
      .frame_tick  (frame_tick),
      .head_idx    (head_idx),
      .cmd_ready   (cmd_ready),
      .ent_fifo    (rd_data[FIFO_W-1:0]),
      .ent_dir     (rd_data[DIR_BIT]),
      .ent_chan    (rd_data[NEXT_LO-1:CHAN_LO]),
      .ent_next    (rd_data[LAST_BIT-1:NEXT_LO]),
      .ent_last    (rd_data[LAST_BIT]),
      .rd_idx      (rd_idx),
      .cmd_valid   (cmd_valid),
      .cmd_fifo    (cmd_fifo),
      .cmd_chan    (cmd_chan),
      .cmd_dir     (cmd_dir),
      .runaway_err (runaway_err),
      .overrun_err (overrun_err)
   );
endmodule

// File: tb/sim_chan_seq_walker.sv
module sim_chan_seq_walker;
   localparam int CLK_PERIOD = 10;
   localparam int NE   = 8;
   localparam int FW   = 6;
   localparam int CW   = 6;
   localparam int SC   = 4;
   localparam int IW   = 3;
   localparam int EW   = FW + CW + IW + 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          seq_mode = 1'b0;
   logic          frame_tick = 1'b0;
   logic [IW-1:0] head_idx = '0;
   logic          cfg_we = 1'b0;
   logic [IW-1:0] cfg_idx = '0;
   logic [EW-1:0] cfg_data = '0;
   logic          cmd_valid;
   logic          cmd_ready = 1'b1;
   logic [FW-1:0] cmd_fifo;
   logic [CW-1:0] cmd_chan;
   logic          cmd_dir;
   logic          runaway_err;
   logic          overrun_err;

   chan_seq_walker #(.ENTRIES(NE), .FIFO_W(FW), .CHAN_W(CW), .SIMPLE_CNT(SC)) u0 (
      .clk(clk), .rst_n(rst_n), .seq_mode(seq_mode), .frame_tick(frame_tick),
      .head_idx(head_idx), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_fifo(cmd_fifo),
      .cmd_chan(cmd_chan), .cmd_dir(cmd_dir), .runaway_err(runaway_err),
      .overrun_err(overrun_err)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;

   int sh_fifo [NE];
   int sh_chan [NE];
   int sh_dir  [NE];
   int sh_next [NE];
   int sh_last [NE];

   int got_f [64];
   int got_c [64];
   int got_d [64];
   int got_n;
   int exp_f [64];
   int exp_c [64];
   int exp_d [64];
   int exp_n;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
         summary();
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input int idx, input int f, input int d, input int c,
                     input int n, input int l, input bit upd);
      @(negedge clk);
      cfg_we   = 1'b1;
      cfg_idx  = IW'(idx);
      cfg_data = {1'(l), IW'(n), CW'(c), 1'(d), FW'(f)};
      if (upd) begin
         sh_fifo[idx] = f; sh_chan[idx] = c; sh_dir[idx] = d;
         sh_next[idx] = n; sh_last[idx] = l;
      end
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // collect handshakes; entered at a falling edge
   task automatic collect(input int ncyc, input bit stall);
      got_n = 0;
      for (int i = 0; i < ncyc; i++) begin
         cmd_ready = stall ? (i % 3 != 0) : 1'b1;
         if (cmd_valid && cmd_ready && got_n < 64) begin
            got_f[got_n] = int'(cmd_fifo);
            got_c[got_n] = int'(cmd_chan);
            got_d[got_n] = int'(cmd_dir);
            got_n++;
         end
         @(negedge clk);
      end
      cmd_ready = 1'b1;
   endtask

   task automatic pulse_frame();
      @(negedge clk);
      frame_tick = 1'b1;
      @(negedge clk);
      frame_tick = 1'b0;
   endtask

   task automatic model_seq(input int head);
      int cur;
      cur = head;
      exp_n = 0;
      for (int k = 0; k < NE; k++) begin
         exp_f[exp_n] = sh_fifo[cur];
         exp_c[exp_n] = sh_chan[cur];
         exp_d[exp_n] = sh_dir[cur];
         exp_n++;
         if (sh_last[cur] != 0) break;
         cur = sh_next[cur];
      end
   endtask

   task automatic model_simple();
      exp_n = SC;
      for (int k = 0; k < SC; k++) begin
         exp_f[k] = k; exp_c[k] = k; exp_d[k] = 0;
      end
   endtask

   task automatic compare(input string req);
      chk(got_n == exp_n, req, "command count", got_n, exp_n);
      for (int k = 0; k < exp_n && k < got_n; k++) begin
         chk(got_f[k] == exp_f[k], req, $sformatf("fifo #%0d", k), got_f[k], exp_f[k]);
         chk(got_c[k] == exp_c[k], req, $sformatf("chan #%0d", k), got_c[k], exp_c[k]);
         chk(got_d[k] == exp_d[k], req, $sformatf("dir #%0d", k), got_d[k], exp_d[k]);
      end
   endtask

   initial begin
      for (int i = 0; i < NE; i++) begin
         sh_fifo[i] = 0; sh_chan[i] = 0; sh_dir[i] = 0; sh_next[i] = 0; sh_last[i] = 0;
      end
      do_reset();

      // R1: reset state
      @(negedge clk);
      chk(cmd_valid == 1'b0, "R1", "cmd_valid", int'(cmd_valid), 0);
      chk(runaway_err == 1'b0, "R1", "runaway_err", int'(runaway_err), 0);
      chk(overrun_err == 1'b0, "R1", "overrun_err", int'(overrun_err), 0);

      // R10: fixed sweep with seq_mode low
      seq_mode = 1'b0;
      pulse_frame();
      collect(20, 1'b0);
      model_simple();
      compare("R10");

      // R5: single-entry list
      seq_mode = 1'b1;
      wr(3, 5, 1, 2, 6, 1, 1'b1);
      head_idx = 3'd3;
      pulse_frame();
      collect(20, 1'b0);
      model_seq(3);
      compare("R5");

      // R3 R4 R2: sweep list lengths 1..NE on a stride-3 chain
      for (int len = 1; len <= NE; len++) begin
         int hd;
         hd = len % NE;
         for (int k = 0; k < len; k++) begin
            int node;
            int nxt;
            node = (hd + 3 * k) % NE;
            nxt  = (hd + 3 * (k + 1)) % NE;
            wr(node, (len % 2 == 0) ? 9 : (k + len), k % 2, (5 * k + len) % 64,
               nxt, (k == len - 1) ? 1 : 0, 1'b1);
         end
         head_idx = IW'(hd);
         pulse_frame();
         collect(40, len % 2 == 1);
         model_seq(hd);
         compare($sformatf("R3 len %0d", len));
      end
      // R6 boundary: full-length list ending on a last entry
      chk(runaway_err == 1'b0, "R6", "runaway after full list", int'(runaway_err), 0);
      chk(overrun_err == 1'b0, "R7", "overrun without early frame", int'(overrun_err), 0);

      // R8: write during a stalled walk is dropped
      head_idx = 3'd0;
      wr(0, 11, 0, 33, 1, 1, 1'b1);
      cmd_ready = 1'b0;
      pulse_frame();
      wr(0, 44, 1, 55, 2, 1, 1'b0);
      collect(10, 1'b0);
      model_seq(0);
      compare("R8");
      pulse_frame();
      collect(10, 1'b0);
      compare("R8 next frame");

      // R7: frame during a stalled walk restarts and flags
      wr(0, 12, 1, 40, 5, 0, 1'b1);
      wr(5, 13, 0, 41, 2, 1, 1'b1);
      cmd_ready = 1'b0;
      pulse_frame();
      repeat (3) @(negedge clk);
      chk(cmd_valid == 1'b1, "R4", "valid held under stall", int'(cmd_valid), 1);
      chk(int'(cmd_fifo) == 12, "R4", "fifo held under stall", int'(cmd_fifo), 12);
      pulse_frame();
      chk(overrun_err == 1'b1, "R7", "overrun_err", int'(overrun_err), 1);
      collect(10, 1'b0);
      model_seq(0);
      compare("R7 restart");
      repeat (4) @(negedge clk);
      chk(overrun_err == 1'b1, "R7", "overrun sticky", int'(overrun_err), 1);

      // R9: clearing the mode aborts the walk
      cmd_ready = 1'b0;
      pulse_frame();
      chk(cmd_valid == 1'b1, "R9", "walk live before abort", int'(cmd_valid), 1);
      seq_mode = 1'b0;
      #1;
      chk(cmd_valid == 1'b0, "R9", "valid drops at mode clear", int'(cmd_valid), 0);
      @(negedge clk);
      collect(10, 1'b0);
      chk(got_n == 0, "R9", "commands after abort", got_n, 0);
      pulse_frame();
      collect(20, 1'b0);
      model_simple();
      compare("R9 then R10");

      // R6: looping list without a last entry
      seq_mode = 1'b1;
      for (int i = 0; i < NE; i++) wr(i, 20 + i, 0, i, (i + 1) % NE, 0, 1'b1);
      head_idx = 3'd2;
      pulse_frame();
      collect(40, 1'b1);
      chk(got_n == NE, "R6", "commands before stop", got_n, NE);
      for (int k = 0; k < got_n; k++)
         chk(got_f[k] == 20 + (2 + k) % NE, "R6", "loop fifo", got_f[k], 20 + (2 + k) % NE);
      chk(runaway_err == 1'b1, "R6", "runaway_err", int'(runaway_err), 1);
      repeat (5) @(negedge clk);
      chk(runaway_err == 1'b1, "R6", "runaway sticky", int'(runaway_err), 1);

      // R1: reset clears flags and table
      do_reset();
      @(negedge clk);
      chk(runaway_err == 1'b0, "R1", "runaway cleared", int'(runaway_err), 0);
      chk(overrun_err == 1'b0, "R1", "overrun cleared", int'(overrun_err), 0);
      // R2: cleared table entry 0 has last=0 and loops on itself with zero fields
      head_idx = 3'd0;
      pulse_frame();
      collect(30, 1'b0);
      chk(got_n == NE, "R2", "cleared-table walk length", got_n, NE);
      chk(got_n > 0 && got_c[0] == 0, "R2", "cleared chan", got_n > 0 ? got_c[0] : -1, 0);

      summary();
   end
endmodule